// File: doc/BRIEF.md
# DMA Firewall with Panic Fence

This block sits on the path between an accelerator's DMA engines and the host bus. Every outbound request carries a context number, an address and a tag. The block checks the address against the window programmed for that context. A request that lands inside the window passes straight through to the downstream port. A request that falls outside the window, or that names a context with no valid window, is stopped. It is answered upstream with an error response, and it raises a violation trigger that a security monitor can use to escalate to shutdown.

A kill input switches the block into a fence. The kill cycle does the following:

- Every window loses its valid bit.
- Nothing more is forwarded.
- Responses still coming back for requests already sent are swallowed instead of being returned.
- A small cache of recently approved pages is zeroed one row per clock.

When the cache is clear and the in-flight count reaches zero, the block reports that the fence is done. It stays fenced until the monitor pulses an explicit release.

The controller has four states:

- RUN: normal checking.
- SCRUB: one cache row zeroed per cycle.
- DRAIN: waiting for outstanding responses.
- HALT: fence complete, waiting for release.

The transitions are:

- RUN goes to SCRUB on kill.
- SCRUB goes to HALT after the last row if nothing is outstanding, and to DRAIN otherwise.
- DRAIN goes to HALT when the in-flight count is zero.
- HALT goes to RUN on release.

Top module: `dmafw_top`

## Requirements
- R1: With the window valid, a request whose address A satisfies base <= A <= limit (both bounds inclusive) appears on the downstream port in the same cycle with address and tag unchanged. The downstream response is relayed upstream in the cycle it arrives, with the same tag and error bit.
- R2: A request outside its context's window, or on a context whose valid bit is 0, is never forwarded. One cycle after acceptance it receives an upstream response with the error bit set and its own tag. In that same cycle, while the block is running, the violation trigger pulses for one cycle and that context's sticky violation flag (bit = context number) is set.
- R3: The configuration address is {context, select}, with select in the two low bits: 0 = base, 1 = inclusive limit, 2 = valid (data bit 0), 3 = violation clear. A write takes effect for requests from the next cycle, and any window write discards every cached page approval.
- R4: A write to select 3 with data bit 0 = 1 clears only that context's violation flag. Data bit 0 = 0 leaves the flags unchanged.
- R5: A kill seen while running raises the fence-active output from the next cycle and clears every window valid bit. A request presented in the kill cycle is not forwarded.
- R6: While the fence is active, responses coming back from downstream are dropped and never returned upstream.
- R7: While the fence is active, including the kill cycle, every request is accepted and rejected with an error response, without setting any violation flag or trigger.
- R8: The fence zeroes one cache row per cycle over all ATC_DEPTH rows. Fence-done asserts only once that scrub is finished and the in-flight count is zero. With nothing in flight, it asserts ATC_DEPTH cycles after fence-active rises.
- R9: Window writes (selects 0 to 2) are ignored while the fence is active.
- R10: A release is honoured only while fence-done is high; a release during SCRUB or DRAIN has no effect. After release, a page approved before the kill is no longer allowed until its window is programmed again.
- R11: At most MAX_OUT requests are outstanding. A further in-window request sees ready low and is not forwarded until a response returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req_valid | input | 1 | Upstream request present |
| up_req_ready | output | 1 | Upstream request accepted this cycle |
| up_req_ctx | input | CTXW | Context of the request |
| up_req_addr | input | AW | Target address |
| up_req_tag | input | TAGW | Transaction tag |
| up_rsp_valid | output | 1 | Response to the DMA side |
| up_rsp_tag | output | TAGW | Tag of that response |
| up_rsp_err | output | 1 | Response reports an error |
| dn_req_valid | output | 1 | Request forwarded to the host bus |
| dn_req_ready | input | 1 | Host bus accepts the request |
| dn_req_addr | output | AW | Forwarded address |
| dn_req_tag | output | TAGW | Forwarded tag |
| dn_rsp_valid | input | 1 | Response from the host bus |
| dn_rsp_tag | input | TAGW | Tag of the host response |
| dn_rsp_err | input | 1 | Host response error bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CTXW+2 | {context, select} |
| cfg_wdata | input | AW | Configuration write data |
| kill | input | 1 | Enter the fence |
| fence_release | input | 1 | Leave the fence (honoured in HALT only) |
| fence_active | output | 1 | Block is fenced (any state but RUN) |
| fence_done | output | 1 | Scrub finished and nothing in flight |
| viol_trig | output | 1 | One-cycle pulse per blocked request |
| viol_flags | output | NCTX | Sticky per-context violation flags |

## Verification
A table of requests probes each window at its exact lower and upper bounds and one address beyond each. It also sends requests from one context into another context's window, and requests to a context that has no valid window, so that an inclusive bound, a missing context compare and a missing valid check each fail on a different entry. Directed sequences then cover the following:

- A window is moved so that a cached approval would let an old address through.
- The outstanding limit is filled and kill then fires with responses still pending, so that dropped responses, the done condition and an early release can each be seen at the ports.
- After release, an address approved before the kill must be refused, which exposes a cache that was not scrubbed or a window write accepted during the fence.

// File: rtl/dmafw_pkg.sv
package dmafw_pkg;

    typedef enum logic [1:0] {
        FW_RUN   = 2'd0,
        FW_SCRUB = 2'd1,
        FW_DRAIN = 2'd2,
        FW_HALT  = 2'd3
    } fw_state_e;

    localparam logic [1:0] SEL_BASE  = 2'd0;
    localparam logic [1:0] SEL_LIMIT = 2'd1;
    localparam logic [1:0] SEL_VALID = 2'd2;
    localparam logic [1:0] SEL_VCLR  = 2'd3;

endpackage

// File: rtl/dmafw_win_table.sv
module dmafw_win_table
    import dmafw_pkg::*;
#(
    parameter int NCTX      = 4,
    parameter int AW        = 32,
    parameter int PAGE_BITS = 12,
    localparam int CTXW     = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CTXW-1:0] wr_ctx,
    input  logic [1:0]      wr_sel,
    input  logic [AW-1:0]   wr_data,
    input  logic            inval_all,
    input  logic [CTXW-1:0] chk_ctx,
    input  logic [AW-1:0]   chk_addr,
    output logic            win_ok,
    output logic            page_ok
);

    logic [AW-1:0]   base_q  [NCTX];
    logic [AW-1:0]   limit_q [NCTX];
    logic [NCTX-1:0] vld_q;

    logic [AW-1:0] sel_base;
    logic [AW-1:0] sel_lim;
    logic          sel_vld;
    logic [AW-1:0] pg_lo;
    logic [AW-1:0] pg_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCTX; c++) begin
                base_q[c]  <= '0;
                limit_q[c] <= '0;
            end
            vld_q <= '0;
        end else begin
            if (wr_en) begin
                unique case (wr_sel)
                    SEL_BASE:  base_q[wr_ctx]  <= wr_data;
                    SEL_LIMIT: limit_q[wr_ctx] <= wr_data;
                    SEL_VALID: vld_q[wr_ctx]   <= wr_data[0];
                    default:   ;
                endcase
            end
            if (inval_all) begin
                vld_q <= '0;
            end
        end
    end

    always_comb begin
        sel_base = base_q[chk_ctx];
        sel_lim  = limit_q[chk_ctx];
        sel_vld  = vld_q[chk_ctx];
        pg_lo    = {chk_addr[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
        pg_hi    = {chk_addr[AW-1:PAGE_BITS], {PAGE_BITS{1'b1}}};
        win_ok   = sel_vld && (chk_addr >= sel_base) && (chk_addr <= sel_lim);
        page_ok  = sel_vld && (pg_lo >= sel_base) && (pg_hi <= sel_lim);
    end

endmodule

// File: rtl/dmafw_atc.sv
module dmafw_atc #(
    parameter int NCTX      = 4,
    parameter int PW        = 20,
    parameter int ATC_DEPTH = 8,
    localparam int CTXW     = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int IDXW     = (ATC_DEPTH > 1) ? $clog2(ATC_DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CTXW-1:0] lk_ctx,
    input  logic [PW-1:0]   lk_page,
    output logic            hit,
    input  logic            ins_en,
    input  logic            flush,
    input  logic            scrub_en,
    input  logic [IDXW-1:0] scrub_idx
);

    localparam logic [IDXW-1:0] LAST_ROW = IDXW'(ATC_DEPTH - 1);

    logic [ATC_DEPTH-1:0] ent_v;
    logic [CTXW-1:0]      ent_ctx [ATC_DEPTH];
    logic [PW-1:0]        ent_pg  [ATC_DEPTH];
    logic [IDXW-1:0]      ptr_q;
    logic [ATC_DEPTH-1:0] hit_vec;

    for (genvar g = 0; g < ATC_DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = ent_v[g] && (ent_ctx[g] == lk_ctx) && (ent_pg[g] == lk_page);
    end

    assign hit = |hit_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_v <= '0;
            ptr_q <= '0;
            for (int i = 0; i < ATC_DEPTH; i++) begin
                ent_ctx[i] <= '0;
                ent_pg[i]  <= '0;
            end
        end else begin
            if (scrub_en) begin
                ent_v[scrub_idx]   <= 1'b0;
                ent_ctx[scrub_idx] <= '0;
                ent_pg[scrub_idx]  <= '0;
                ptr_q              <= '0;
            end else if (ins_en) begin
                ent_v[ptr_q]   <= 1'b1;
                ent_ctx[ptr_q] <= lk_ctx;
                ent_pg[ptr_q]  <= lk_page;
                ptr_q          <= (ptr_q == LAST_ROW) ? '0 : ptr_q + 1'b1;
            end
            if (flush) begin
                ent_v <= '0;
            end
        end
    end

endmodule

// File: rtl/dmafw_fence_fsm.sv
module dmafw_fence_fsm
    import dmafw_pkg::*;
#(
    parameter int ATC_DEPTH = 8,
    localparam int IDXW     = (ATC_DEPTH > 1) ? $clog2(ATC_DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kill,
    input  logic            rel_req,
    input  logic            drained,
    output logic            running,
    output logic            kill_take,
    output logic            fence_active,
    output logic            fence_done,
    output logic            scrub_en,
    output logic [IDXW-1:0] scrub_idx
);

    localparam logic [IDXW-1:0] LAST_ROW = IDXW'(ATC_DEPTH - 1);

    fw_state_e       state_q;
    fw_state_e       state_nx;
    logic [IDXW-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FW_RUN;
            row_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q == FW_SCRUB && row_q != LAST_ROW) begin
                row_q <= row_q + 1'b1;
            end else begin
                row_q <= '0;
            end
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            FW_RUN: begin
                if (kill) state_nx = FW_SCRUB;
            end
            FW_SCRUB: begin
                if (row_q == LAST_ROW) state_nx = drained ? FW_HALT : FW_DRAIN;
            end
            FW_DRAIN: begin
                if (drained) state_nx = FW_HALT;
            end
            FW_HALT: begin
                if (rel_req && !kill) state_nx = FW_RUN;
            end
            default: state_nx = FW_RUN;
        endcase
    end

    always_comb begin
        running      = 1'b0;
        kill_take    = 1'b0;
        fence_active = 1'b1;
        fence_done   = 1'b0;
        scrub_en     = 1'b0;
        scrub_idx    = row_q;
        unique case (state_q)
            FW_RUN: begin
                fence_active = 1'b0;
                running      = !kill;
                kill_take    = kill;
            end
            FW_SCRUB: scrub_en   = 1'b1;
            FW_DRAIN: ;
            FW_HALT:  fence_done = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/dmafw_top.sv
module dmafw_top
    import dmafw_pkg::*;
#(
    parameter int NCTX      = 4,
    parameter int AW        = 32,
    parameter int TAGW      = 4,
    parameter int PAGE_BITS = 12,
    parameter int ATC_DEPTH = 8,
    parameter int MAX_OUT   = 8,
    localparam int CTXW     = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int CFGW     = CTXW + 2,
    localparam int OUTW     = $clog2(MAX_OUT + 1),
    localparam int IDXW     = (ATC_DEPTH > 1) ? $clog2(ATC_DEPTH) : 1,
    localparam int PW       = AW - PAGE_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            up_req_valid,
    output logic            up_req_ready,
    input  logic [CTXW-1:0] up_req_ctx,
    input  logic [AW-1:0]   up_req_addr,
    input  logic [TAGW-1:0] up_req_tag,
    output logic            up_rsp_valid,
    output logic [TAGW-1:0] up_rsp_tag,
    output logic            up_rsp_err,
    output logic            dn_req_valid,
    input  logic            dn_req_ready,
    output logic [AW-1:0]   dn_req_addr,
    output logic [TAGW-1:0] dn_req_tag,
    input  logic            dn_rsp_valid,
    input  logic [TAGW-1:0] dn_rsp_tag,
    input  logic            dn_rsp_err,
    input  logic            cfg_we,
    input  logic [CFGW-1:0] cfg_addr,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic            kill,
    input  logic            fence_release,
    output logic            fence_active,
    output logic            fence_done,
    output logic            viol_trig,
    output logic [NCTX-1:0] viol_flags
);

    localparam logic [OUTW-1:0] OUT_CAP = OUTW'(MAX_OUT);

    logic            running;
    logic            kill_take;
    logic            scrub_en;
    logic [IDXW-1:0] scrub_idx;
    logic            win_ok;
    logic            page_ok;
    logic            atc_hit;

    logic [CTXW-1:0] cfg_ctx;
    logic [1:0]      cfg_sel;
    logic            win_wr;
    logic            vclr_wr;

    logic            allowed;
    logic            cnt_full;
    logic            fwd_fire;
    logic            blk_fire;
    logic            viol_hit;
    logic            rsp_fwd;
    logic            ins_en;

    logic [OUTW-1:0] inflight_q;
    logic            err_pend_q;
    logic [TAGW-1:0] err_tag_q;
    logic            viol_trig_q;
    logic [NCTX-1:0] flags_q;

    assign cfg_ctx = cfg_addr[CFGW-1:2];
    assign cfg_sel = cfg_addr[1:0];
    assign win_wr  = cfg_we && !fence_active && (cfg_sel != SEL_VCLR);
    assign vclr_wr = cfg_we && (cfg_sel == SEL_VCLR) && cfg_wdata[0];

    dmafw_fence_fsm #(
        .ATC_DEPTH (ATC_DEPTH)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .kill         (kill),
        .rel_req      (fence_release),
        .drained      (inflight_q == '0),
        .running      (running),
        .kill_take    (kill_take),
        .fence_active (fence_active),
        .fence_done   (fence_done),
        .scrub_en     (scrub_en),
        .scrub_idx    (scrub_idx)
    );

    dmafw_win_table #(
        .NCTX      (NCTX),
        .AW        (AW),
        .PAGE_BITS (PAGE_BITS)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (win_wr),
        .wr_ctx    (cfg_ctx),
        .wr_sel    (cfg_sel),
        .wr_data   (cfg_wdata),
        .inval_all (kill_take),
        .chk_ctx   (up_req_ctx),
        .chk_addr  (up_req_addr),
        .win_ok    (win_ok),
        .page_ok   (page_ok)
    );

    dmafw_atc #(
        .NCTX      (NCTX),
        .PW        (PW),
        .ATC_DEPTH (ATC_DEPTH)
    ) u_atc (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_ctx    (up_req_ctx),
        .lk_page   (up_req_addr[AW-1:PAGE_BITS]),
        .hit       (atc_hit),
        .ins_en    (ins_en),
        .flush     (win_wr),
        .scrub_en  (scrub_en),
        .scrub_idx (scrub_idx)
    );

    // request path: forward approved traffic, reject the rest into a one-entry error slot
    always_comb begin
        allowed      = running && (atc_hit || win_ok);
        cnt_full     = (inflight_q == OUT_CAP);
        dn_req_valid = up_req_valid && allowed && !cnt_full;
        dn_req_addr  = up_req_addr;
        dn_req_tag   = up_req_tag;
        up_req_ready = allowed ? (dn_req_ready && !cnt_full) : !err_pend_q;
        fwd_fire     = dn_req_valid && dn_req_ready;
        blk_fire     = up_req_valid && !allowed && !err_pend_q;
        viol_hit     = blk_fire && running;
        ins_en       = fwd_fire && page_ok && !atc_hit;
    end

    // response path: host responses only while running; errors wait behind them
    always_comb begin
        rsp_fwd = dn_rsp_valid && running;
        if (rsp_fwd) begin
            up_rsp_valid = 1'b1;
            up_rsp_tag   = dn_rsp_tag;
            up_rsp_err   = dn_rsp_err;
        end else begin
            up_rsp_valid = err_pend_q;
            up_rsp_tag   = err_tag_q;
            up_rsp_err   = err_pend_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inflight_q <= '0;
        end else begin
            unique case ({fwd_fire, dn_rsp_valid && (inflight_q != '0)})
                2'b10:   inflight_q <= inflight_q + 1'b1;
                2'b01:   inflight_q <= inflight_q - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_pend_q  <= 1'b0;
            err_tag_q   <= '0;
            viol_trig_q <= 1'b0;
        end else begin
            viol_trig_q <= viol_hit;
            if (blk_fire) begin
                err_pend_q <= 1'b1;
                err_tag_q  <= up_req_tag;
            end else if (err_pend_q && !rsp_fwd) begin
                err_pend_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            for (int c = 0; c < NCTX; c++) begin
                if (viol_hit && (up_req_ctx == CTXW'(c))) begin
                    flags_q[c] <= 1'b1;
                end else if (vclr_wr && (cfg_ctx == CTXW'(c))) begin
                    flags_q[c] <= 1'b0;
                end
            end
        end
    end

    assign viol_trig  = viol_trig_q;
    assign viol_flags = flags_q;

endmodule

// File: rtl/dmafw_checker.sv
module dmafw_checker #(
    parameter int NCTX = 4,
    parameter int OUTW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            kill,
    input logic            fence_release,
    input logic            fence_active,
    input logic            fence_done,
    input logic            dn_req_valid,
    input logic            up_rsp_valid,
    input logic            up_rsp_err,
    input logic            viol_trig,
    input logic [NCTX-1:0] viol_flags,
    input logic [OUTW-1:0] inflight
);

    a_r5_kill_enters_fence: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !fence_active) |=> fence_active);

    a_r7_no_forward_when_fenced: assert property (@(posedge clk) disable iff (!rst_n)
        fence_active |-> !dn_req_valid);

    a_r6_only_errors_when_fenced: assert property (@(posedge clk) disable iff (!rst_n)
        fence_active |-> !(up_rsp_valid && !up_rsp_err));

    a_r8_done_means_drained: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> (inflight == '0));

    a_r8_done_inside_fence: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> fence_active);

    a_r10_exit_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fence_active) |-> ($past(fence_release) && $past(fence_done)));

    a_r2_trigger_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        viol_trig |-> (viol_flags != '0));

    a_r7_no_trigger_when_fenced: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fence_active) |-> !viol_trig);

endmodule

bind dmafw_top dmafw_checker #(
    .NCTX (NCTX),
    .OUTW (OUTW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .kill          (kill),
    .fence_release (fence_release),
    .fence_active  (fence_active),
    .fence_done    (fence_done),
    .dn_req_valid  (dn_req_valid),
    .up_rsp_valid  (up_rsp_valid),
    .up_rsp_err    (up_rsp_err),
    .viol_trig     (viol_trig),
    .viol_flags    (viol_flags),
    .inflight      (inflight_q)
);

// File: tb/dmafw_top_tb.sv
module dmafw_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCTX       = 4;
    localparam int AW         = 32;
    localparam int TAGW       = 4;
    localparam int ATC_DEPTH  = 8;
    localparam int MAX_OUT    = 8;
    localparam int WDOG       = 20000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            up_req_valid = 1'b0;
    logic            up_req_ready;
    logic [1:0]      up_req_ctx = '0;
    logic [AW-1:0]   up_req_addr = '0;
    logic [TAGW-1:0] up_req_tag = '0;
    logic            up_rsp_valid;
    logic [TAGW-1:0] up_rsp_tag;
    logic            up_rsp_err;
    logic            dn_req_valid;
    logic            dn_req_ready = 1'b1;
    logic [AW-1:0]   dn_req_addr;
    logic [TAGW-1:0] dn_req_tag;
    logic            dn_rsp_valid = 1'b0;
    logic [TAGW-1:0] dn_rsp_tag = '0;
    logic            dn_rsp_err = 1'b0;
    logic            cfg_we = 1'b0;
    logic [3:0]      cfg_addr = '0;
    logic [AW-1:0]   cfg_wdata = '0;
    logic            kill = 1'b0;
    logic            fence_release = 1'b0;
    logic            fence_active;
    logic            fence_done;
    logic            viol_trig;
    logic [NCTX-1:0] viol_flags;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmafw_top #(
        .NCTX      (NCTX),
        .AW        (AW),
        .TAGW      (TAGW),
        .ATC_DEPTH (ATC_DEPTH),
        .MAX_OUT   (MAX_OUT)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .up_req_valid (up_req_valid), .up_req_ready (up_req_ready),
        .up_req_ctx (up_req_ctx), .up_req_addr (up_req_addr), .up_req_tag (up_req_tag),
        .up_rsp_valid (up_rsp_valid), .up_rsp_tag (up_rsp_tag), .up_rsp_err (up_rsp_err),
        .dn_req_valid (dn_req_valid), .dn_req_ready (dn_req_ready),
        .dn_req_addr (dn_req_addr), .dn_req_tag (dn_req_tag),
        .dn_rsp_valid (dn_rsp_valid), .dn_rsp_tag (dn_rsp_tag), .dn_rsp_err (dn_rsp_err),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
        .kill (kill), .fence_release (fence_release),
        .fence_active (fence_active), .fence_done (fence_done),
        .viol_trig (viol_trig), .viol_flags (viol_flags)
    );

    typedef struct packed {
        logic [1:0]    ctx;
        logic [AW-1:0] addr;
        logic          pass;
    } vec_t;

    // windows: ctx0 [0x1000,0x1FFF], ctx1 [0x2000,0x2FFF], ctx2 [0x3000,0x30FF], ctx3 invalid
    localparam vec_t VECS [9] = '{
        '{2'd0, 32'h0000_1000, 1'b1},
        '{2'd0, 32'h0000_1FFF, 1'b1},
        '{2'd0, 32'h0000_2000, 1'b0},
        '{2'd0, 32'h0000_0FFF, 1'b0},
        '{2'd1, 32'h0000_2000, 1'b1},
        '{2'd1, 32'h0000_1500, 1'b0},
        '{2'd3, 32'h0000_1000, 1'b0},
        '{2'd2, 32'h0000_30FF, 1'b1},
        '{2'd2, 32'h0000_3100, 1'b0}
    };

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] ctx, input logic [1:0] sel, input logic [AW-1:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {ctx, sel};
        cfg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    // one request; if forwarded, the bench answers it in the following cycle
    task automatic do_req(input logic [1:0] ctx, input logic [AW-1:0] addr, input logic [TAGW-1:0] tag,
                          output bit fwd, output bit pay_ok, output bit rsp_ok, output bit trig);
        @(negedge clk);
        up_req_valid = 1'b1;
        up_req_ctx   = ctx;
        up_req_addr  = addr;
        up_req_tag   = tag;
        #1;
        fwd    = dn_req_valid;
        pay_ok = (dn_req_addr == addr) && (dn_req_tag == tag);
        @(posedge clk);
        @(negedge clk);
        up_req_valid = 1'b0;
        if (fwd) begin
            dn_rsp_valid = 1'b1;
            dn_rsp_tag   = tag;
            dn_rsp_err   = 1'b0;
            #1;
            rsp_ok = up_rsp_valid && !up_rsp_err && (up_rsp_tag == tag);
            trig   = viol_trig;
            @(posedge clk);
            @(negedge clk);
            dn_rsp_valid = 1'b0;
        end else begin
            #1;
            rsp_ok = up_rsp_valid && up_rsp_err && (up_rsp_tag == tag);
            trig   = viol_trig;
            @(posedge clk);
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit fwd, pay_ok, rsp_ok, trig;
        int n;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R5 reset fence_active", fence_active, 0);
        chk("R8 reset fence_done", fence_done, 0);
        chk("R2 reset flags", viol_flags, 0);
        chk("R1 reset up_rsp_valid", up_rsp_valid, 0);

        cfg_write(2'd0, 2'd0, 32'h1000); cfg_write(2'd0, 2'd1, 32'h1FFF); cfg_write(2'd0, 2'd2, 32'h1);
        cfg_write(2'd1, 2'd0, 32'h2000); cfg_write(2'd1, 2'd1, 32'h2FFF); cfg_write(2'd1, 2'd2, 32'h1);
        cfg_write(2'd2, 2'd0, 32'h3000); cfg_write(2'd2, 2'd1, 32'h30FF); cfg_write(2'd2, 2'd2, 32'h1);

        // R1 / R2 table walk
        for (int i = 0; i < 9; i++) begin
            do_req(VECS[i].ctx, VECS[i].addr, TAGW'(i), fwd, pay_ok, rsp_ok, trig);
            if (VECS[i].pass) begin
                chk("R1 forwarded", fwd, 1);
                chk("R1 payload unchanged", pay_ok, 1);
                chk("R1 response relayed", rsp_ok, 1);
                chk("R1 no trigger", trig, 0);
            end else begin
                chk("R2 not forwarded", fwd, 0);
                chk("R2 error response", rsp_ok, 1);
                chk("R2 trigger pulse", trig, 1);
            end
        end
        chk("R2 sticky flags", viol_flags, 4'b1111);

        // R4 write-one-to-clear
        cfg_write(2'd1, 2'd3, 32'h0);
        chk("R4 zero write no effect", viol_flags, 4'b1111);
        cfg_write(2'd1, 2'd3, 32'h1);
        chk("R4 clears only ctx1", viol_flags, 4'b1101);
        cfg_write(2'd0, 2'd3, 32'h1); cfg_write(2'd2, 2'd3, 32'h1); cfg_write(2'd3, 2'd3, 32'h1);
        chk("R4 all cleared", viol_flags, 4'b0000);

        // R3 moving a window drops the old range and cached approvals
        cfg_write(2'd1, 2'd0, 32'h5000);
        cfg_write(2'd1, 2'd1, 32'h5003);
        do_req(2'd1, 32'h5003, 4'd1, fwd, pay_ok, rsp_ok, trig);
        chk("R3 new limit inclusive", fwd, 1);
        do_req(2'd1, 32'h5004, 4'd2, fwd, pay_ok, rsp_ok, trig);
        chk("R3 beyond new limit", fwd, 0);
        do_req(2'd1, 32'h2000, 4'd3, fwd, pay_ok, rsp_ok, trig);
        chk("R3 old range refused", fwd, 0);
        cfg_write(2'd1, 2'd3, 32'h1);

        // R11 fill outstanding limit
        for (int i = 0; i < MAX_OUT; i++) begin
            @(negedge clk);
            up_req_valid = 1'b1;
            up_req_ctx   = 2'd0;
            up_req_addr  = 32'h1000 + AW'(i * 4);
            up_req_tag   = TAGW'(i);
            #1;
            chk("R11 forwarded below limit", dn_req_valid, 1);
            @(posedge clk);
        end
        @(negedge clk);
        up_req_tag = 4'd8;
        #1;
        chk("R11 ready low at limit", up_req_ready, 0);
        chk("R11 not forwarded at limit", dn_req_valid, 0);
        @(posedge clk);

        // R5 kill cycle
        @(negedge clk);
        kill       = 1'b1;
        up_req_tag = 4'd9;
        #1;
        chk("R5 kill cycle not forwarded", dn_req_valid, 0);
        chk("R5 kill cycle request taken as reject", up_req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        kill         = 1'b0;
        up_req_valid = 1'b0;
        #1;
        chk("R5 fence active", fence_active, 1);
        chk("R7 reject response", {up_rsp_valid, up_rsp_err, up_rsp_tag}, {2'b11, 4'd9});
        chk("R7 no trigger", viol_trig, 0);
        chk("R7 no flag", viol_flags, 0);

        // R10 early release ignored
        fence_release = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fence_release = 1'b0;
        #1;
        chk("R10 early release ignored", fence_active, 1);
        repeat (12) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R8 not done with traffic in flight", fence_done, 0);

        // R9 window write during fence
        cfg_write(2'd0, 2'd2, 32'h1);

        // R6 responses dropped
        for (int i = 0; i < MAX_OUT; i++) begin
            @(negedge clk);
            dn_rsp_valid = 1'b1;
            dn_rsp_tag   = TAGW'(i);
            #1;
            chk("R6 response dropped", up_rsp_valid, 0);
            @(posedge clk);
        end
        @(negedge clk);
        dn_rsp_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R8 done after drain", fence_done, 1);

        do_req(2'd0, 32'h1000, 4'd3, fwd, pay_ok, rsp_ok, trig);
        chk("R7 fenced request not forwarded", fwd, 0);
        chk("R7 fenced request error", rsp_ok, 1);
        chk("R7 fenced request no trigger", trig, 0);
        chk("R7 fenced request no flag", viol_flags, 0);

        @(negedge clk);
        fence_release = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fence_release = 1'b0;
        #1;
        chk("R10 release leaves fence", fence_active, 0);
        chk("R10 done drops", fence_done, 0);

        do_req(2'd0, 32'h1000, 4'd4, fwd, pay_ok, rsp_ok, trig);
        chk("R10 cached page refused after release", fwd, 0);
        chk("R9 fenced window write ignored", viol_flags, 4'b0001);
        cfg_write(2'd0, 2'd3, 32'h1);
        do_req(2'd1, 32'h5000, 4'd5, fwd, pay_ok, rsp_ok, trig);
        chk("R5 valid bits cleared by kill", fwd, 0);
        cfg_write(2'd1, 2'd3, 32'h1);

        // R8 timing with nothing in flight
        cfg_write(2'd0, 2'd2, 32'h1);
        do_req(2'd0, 32'h1000, 4'd6, fwd, pay_ok, rsp_ok, trig);
        chk("R9 window write accepted after release", fwd, 1);
        @(negedge clk);
        kill = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        kill = 1'b0;
        #1;
        chk("R5 fence active after kill", fence_active, 1);
        while (!fence_done && n < 50) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            #1;
        end
        chk("R8 scrub length", n, ATC_DEPTH + 1);
        @(negedge clk);
        fence_release = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fence_release = 1'b0;
        #1;
        chk("R10 second release", fence_active, 0);

        finish_run();
    end

endmodule